// File: doc/BRIEF.md
# Transmit Checksum Offload Classifier

This block watches an outgoing Ethernet frame one byte per accepted cycle. It parses the layer-2 encapsulation and the IP header. From these it decides whether a later checksum engine may insert an IPv4 header checksum, a TCP/UDP checksum, or neither. It does no checksum arithmetic. It produces a 3-bit verdict code that the transmit path writes into the frame's descriptor status, plus two permission flags.

The parser handles an untagged frame, a single 802.1Q tag, and an LLC/SNAP header with a length field. Each of these may be followed by an IPv4 header (with options) or a fixed IPv6 header, and then by the start of a TCP or UDP header. The verdict is returned one cycle after the end-of-frame byte. It stays on the outputs until the next frame ends. A per-frame bypass flag, sampled with the first byte, turns off all offload for frames that already carry their own CRC.

Top module: `txcs_classify`

## Requirements
- R1: After reset `res_valid` is low and `res_code`, `res_ip_ok` and `res_l4_ok` are all zero.
- R2: Only cycles with `in_valid` high are parsed, and `in_sop`/`in_eop` are ignored otherwise. For each accepted end-of-frame byte, `res_valid` pulses for exactly one cycle on the following cycle. The three result outputs keep their value until the next result.
- R3: Byte 0 of a frame is the first destination-address byte, and the type/length field is at bytes 12-13. An IPv4 frame (type 0x0800, version 4, IHL 5 to 15) whose TCP (protocol 6) header reaches at least 18 bytes, or whose UDP (protocol 17) header reaches at least 8 bytes, reports code 000 with `res_ip_ok`=1 and `res_l4_ok`=1. The same holds for IPv6 (type 0x86DD, version 6, next header at byte 6 of a 40-byte header), except that `res_ip_ok`=0. `res_l4_ok`=1 only ever comes with code 000.
- R4: Type 0x8100 is a 4-byte tag whose inner type/length follows it. A second 0x8100 in that position, or a frame that ends before the inner type is complete, gives code 001.
- R5: A type/length of 1500 or less starts an 8-byte SNAP header: bytes AA, AA, 03, three organisation bytes, then a type. If the frame ends inside that header, the code is 010. If any of the first three bytes differ from AA, AA, 03, the code is 100.
- R6: A frame that ends before bytes 12-13 are complete reports code 100. So does an outer type that is none of 0x8100, 0x0800, 0x86DD or a length.
- R7: Code 011 is reported in these cases, with both flags 0:
  - a type found after a tag or SNAP header is not 0x0800/0x86DD (this includes a length or 0x8100 after SNAP);
  - an IPv4 first byte has a version other than 4, or an IHL below 5;
  - an IPv6 version is not 6;
  - the frame ends inside the IP header.
- R8: An IPv4 header with MF (bit 5 of header byte 6) set, or a nonzero 13-bit fragment offset (byte 6 bits 4:0 and byte 7), gives code 101 with `res_ip_ok`=1. An IPv6 next header of 44 gives code 101 with `res_ip_ok`=0.
- R9: A complete, unfragmented IP header whose protocol/next header is neither 6 nor 17 gives code 110, with `res_ip_ok`=1 for IPv4 and 0 for IPv6, and `res_l4_ok`=0. `res_ip_ok`=1 only comes with codes 000, 101, 110 or 111.
- R10: A frame that ends after a complete TCP/UDP-bearing IP header but before the L4 checksum field is complete gives code 111. `res_ip_ok` is 1 for IPv4 and 0 for IPv6, and `res_l4_ok`=0.
- R11: If `in_nocrc` is high with the start-of-frame byte, the result is code 000 with both flags 0, whatever the frame holds.
- R12: An `in_sop` byte arriving inside a frame discards the unfinished frame without a result and starts a new parse at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sop | input | 1 | This byte is byte 0 of a frame |
| in_eop | input | 1 | This byte is the last of the frame |
| in_nocrc | input | 1 | Frame carries its own CRC; sampled with `in_sop` |
| in_data | input | 8 | Frame byte |
| res_valid | output | 1 | One-cycle pulse: result for the frame just ended |
| res_code | output | 3 | Verdict code |
| res_ip_ok | output | 1 | IPv4 header checksum may be inserted |
| res_l4_ok | output | 1 | TCP/UDP checksum may be inserted |

## Verification
A wrong parse state shows as a wrong `res_code` on the cycle after the end-of-frame byte. The bench therefore ends frames on each boundary byte: inside the tag, inside the SNAP header, on the last IP header byte, and one byte short of the L4 checksum field. An off-by-one in the field counter moves the verdict by one code at exactly these lengths. A stale flag from a previous frame shows up when the next frame's verdict carries a permission that frame never earned. A frame that is restarted mid-way must produce exactly one verdict.

// File: rtl/txcs_pkg.sv
package txcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MAC,
        ST_TYPE,
        ST_VTAG,
        ST_SNAP,
        ST_IP4,
        ST_IP6,
        ST_L4,
        ST_DONE
    } parse_st_e;

    localparam logic [2:0] CODE_OK      = 3'b000;
    localparam logic [2:0] CODE_VLAN    = 3'b001;
    localparam logic [2:0] CODE_SNAP    = 3'b010;
    localparam logic [2:0] CODE_NOTIP   = 3'b011;
    localparam logic [2:0] CODE_UNKNOWN = 3'b100;
    localparam logic [2:0] CODE_FRAG    = 3'b101;
    localparam logic [2:0] CODE_NOL4    = 3'b110;
    localparam logic [2:0] CODE_SHORT   = 3'b111;

    localparam logic [15:0] ETH_VLAN = 16'h8100;
    localparam logic [15:0] ETH_IPV4 = 16'h0800;
    localparam logic [15:0] ETH_IPV6 = 16'h86DD;

    localparam logic [7:0] PROTO_TCP  = 8'd6;
    localparam logic [7:0] PROTO_UDP  = 8'd17;
    localparam logic [7:0] PROTO_FRAG = 8'd44;

endpackage

// File: rtl/txcs_type_decode.sv
module txcs_type_decode
    import txcs_pkg::*;
#(
    parameter int MAX_LEN = 1500
) (
    input  logic [15:0] tval,
    output logic        is_vlan,
    output logic        is_v4,
    output logic        is_v6,
    output logic        is_len
);
    localparam logic [15:0] LEN_LIMIT = 16'(MAX_LEN);

    always_comb begin
        is_vlan = (tval == ETH_VLAN);
        is_v4   = (tval == ETH_IPV4);
        is_v6   = (tval == ETH_IPV6);
        is_len  = (tval <= LEN_LIMIT);
    end
endmodule

// File: rtl/txcs_l4_select.sv
module txcs_l4_select
    import txcs_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int TCP_NEED = 18,
    parameter int UDP_NEED = 8
) (
    input  logic [7:0]       proto,
    output logic             supp,
    output logic             frag6,
    output logic [CNT_W-1:0] need
);
    localparam logic [CNT_W-1:0] TCP_N = CNT_W'(TCP_NEED);
    localparam logic [CNT_W-1:0] UDP_N = CNT_W'(UDP_NEED);

    always_comb begin
        supp  = (proto == PROTO_TCP) || (proto == PROTO_UDP);
        frag6 = (proto == PROTO_FRAG);
        need  = (proto == PROTO_TCP) ? TCP_N : UDP_N;
    end
endmodule

// File: rtl/txcs_classify.sv
module txcs_classify
    import txcs_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int MAX_LEN  = 1500,
    parameter int TCP_NEED = 18,
    parameter int UDP_NEED = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic       in_nocrc,
    input  logic [7:0] in_data,
    output logic       res_valid,
    output logic [2:0] res_code,
    output logic       res_ip_ok,
    output logic       res_l4_ok
);
    localparam logic [CNT_W-1:0] MAC_LAST  = CNT_W'(11);
    localparam logic [CNT_W-1:0] SNAP_LAST = CNT_W'(5);
    localparam logic [CNT_W-1:0] IP6_LAST  = CNT_W'(39);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    typedef struct packed {
        parse_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hlen;
        logic [CNT_W-1:0] need;
        logic [7:0]       type_hi;
        logic [7:0]       proto;
        logic             vlan;
        logic             snap;
        logic             v4;
        logic             frag;
        logic             nocrc;
        logic [2:0]       code;
        logic             ipok;
        logic             l4ok;
        logic             res_valid;
        logic [2:0]       res_code;
        logic             res_ip;
        logic             res_l4;
    } cls_state_t;

    cls_state_t d, q;

    logic             is_vlan, is_v4, is_v6, is_len;
    logic             l4_supp, l4_frag6;
    logic [CNT_W-1:0] l4_need;
    parse_st_e        cur_st;
    logic [CNT_W-1:0] cur_cnt;

    txcs_type_decode #(.MAX_LEN(MAX_LEN)) u_type (
        .tval    ({q.type_hi, in_data}),
        .is_vlan (is_vlan),
        .is_v4   (is_v4),
        .is_v6   (is_v6),
        .is_len  (is_len)
    );

    txcs_l4_select #(.CNT_W(CNT_W), .TCP_NEED(TCP_NEED), .UDP_NEED(UDP_NEED)) u_l4 (
        .proto (q.proto),
        .supp  (l4_supp),
        .frag6 (l4_frag6),
        .need  (l4_need)
    );

    assign cur_st  = in_sop ? ST_MAC : q.st;
    assign cur_cnt = in_sop ? '0 : q.cnt;

    always_comb begin
        d = q;
        d.res_valid = 1'b0;
        if (in_valid) begin
            if (in_sop) begin
                d.vlan  = 1'b0;
                d.snap  = 1'b0;
                d.v4    = 1'b0;
                d.frag  = 1'b0;
                d.nocrc = in_nocrc;
                d.code  = CODE_OK;
                d.ipok  = 1'b0;
                d.l4ok  = 1'b0;
            end
            d.cnt = cur_cnt + ONE;
            case (cur_st)
                ST_MAC: begin
                    d.st = ST_MAC;
                    if (cur_cnt == MAC_LAST) begin
                        d.st  = ST_TYPE;
                        d.cnt = '0;
                    end
                end
                ST_TYPE: begin
                    if (cur_cnt == '0) begin
                        d.type_hi = in_data;
                    end else begin
                        d.cnt = '0;
                        if (is_vlan && !q.vlan && !q.snap) begin
                            d.vlan = 1'b1;
                            d.st   = ST_VTAG;
                        end else if (is_v4) begin
                            d.v4 = 1'b1;
                            d.st = ST_IP4;
                        end else if (is_v6) begin
                            d.st = ST_IP6;
                        end else if (is_len && !q.snap) begin
                            d.st = ST_SNAP;
                        end else if (is_vlan && !q.snap) begin
                            d.st   = ST_DONE;
                            d.code = CODE_VLAN;
                        end else begin
                            d.st   = ST_DONE;
                            d.code = (q.vlan || q.snap) ? CODE_NOTIP : CODE_UNKNOWN;
                        end
                    end
                end
                ST_VTAG: begin
                    if (cur_cnt == ONE) begin
                        d.st  = ST_TYPE;
                        d.cnt = '0;
                    end
                end
                ST_SNAP: begin
                    if ((cur_cnt < CNT_W'(2) && in_data != 8'hAA) ||
                        (cur_cnt == CNT_W'(2) && in_data != 8'h03)) begin
                        d.st   = ST_DONE;
                        d.code = CODE_UNKNOWN;
                    end else if (cur_cnt == SNAP_LAST) begin
                        d.st   = ST_TYPE;
                        d.cnt  = '0;
                        d.snap = 1'b1;
                    end
                end
                ST_IP4: begin
                    if (cur_cnt == '0) begin
                        if (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5) begin
                            d.st   = ST_DONE;
                            d.code = CODE_NOTIP;
                        end else begin
                            d.hlen = CNT_W'(in_data[3:0]) << 2;
                        end
                    end else if (cur_cnt == CNT_W'(6)) begin
                        d.frag = in_data[5] | (|in_data[4:0]);
                    end else if (cur_cnt == CNT_W'(7)) begin
                        d.frag = q.frag | (|in_data);
                    end else if (cur_cnt == CNT_W'(9)) begin
                        d.proto = in_data;
                    end else if (cur_cnt == q.hlen - ONE) begin
                        d.cnt  = '0;
                        d.ipok = 1'b1;
                        if (q.frag) begin
                            d.st   = ST_DONE;
                            d.code = CODE_FRAG;
                        end else if (l4_supp) begin
                            d.st   = ST_L4;
                            d.need = l4_need;
                        end else begin
                            d.st   = ST_DONE;
                            d.code = CODE_NOL4;
                        end
                    end
                end
                ST_IP6: begin
                    if (cur_cnt == '0) begin
                        if (in_data[7:4] != 4'd6) begin
                            d.st   = ST_DONE;
                            d.code = CODE_NOTIP;
                        end
                    end else if (cur_cnt == CNT_W'(6)) begin
                        d.proto = in_data;
                    end else if (cur_cnt == IP6_LAST) begin
                        d.cnt = '0;
                        if (l4_frag6) begin
                            d.st   = ST_DONE;
                            d.code = CODE_FRAG;
                        end else if (l4_supp) begin
                            d.st   = ST_L4;
                            d.need = l4_need;
                        end else begin
                            d.st   = ST_DONE;
                            d.code = CODE_NOL4;
                        end
                    end
                end
                ST_L4: begin
                    if (cur_cnt == q.need - ONE) begin
                        d.st   = ST_DONE;
                        d.code = CODE_OK;
                        d.l4ok = 1'b1;
                    end
                end
                ST_DONE: d.cnt = q.cnt;
                default: d.cnt = q.cnt;
            endcase

            if (in_eop && cur_st != ST_IDLE) begin
                d.res_valid = 1'b1;
                d.res_ip    = 1'b0;
                d.res_l4    = 1'b0;
                case (d.st)
                    ST_TYPE: d.res_code = d.snap ? CODE_SNAP :
                                          (d.vlan ? CODE_VLAN : CODE_UNKNOWN);
                    ST_VTAG: d.res_code = CODE_VLAN;
                    ST_SNAP: d.res_code = CODE_SNAP;
                    ST_IP4,
                    ST_IP6:  d.res_code = CODE_NOTIP;
                    ST_L4: begin
                        d.res_code = CODE_SHORT;
                        d.res_ip   = d.v4;
                    end
                    ST_DONE: begin
                        d.res_code = d.code;
                        d.res_ip   = d.ipok;
                        d.res_l4   = d.l4ok;
                    end
                    default: d.res_code = CODE_UNKNOWN;
                endcase
                if (d.nocrc) begin
                    d.res_code = CODE_OK;
                    d.res_ip   = 1'b0;
                    d.res_l4   = 1'b0;
                end
                d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign res_valid = q.res_valid;
    assign res_code  = q.res_code;
    assign res_ip_ok = q.res_ip;
    assign res_l4_ok = q.res_l4;

endmodule

// File: rtl/txcs_checker.sv
module txcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_sop,
    input logic       in_eop,
    input logic       in_nocrc,
    input logic       res_valid,
    input logic [2:0] res_code,
    input logic       res_ip_ok,
    input logic       res_l4_ok
);
    logic bypass_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 bypass_seen <= 1'b0;
        else if (in_valid && in_sop) bypass_seen <= in_nocrc;
    end

    AST_RESULT_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_eop)); // R2

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !(in_valid && in_eop) |=> !res_valid); // R2

    AST_L4_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_l4_ok |-> res_code == 3'b000); // R3

    AST_CLEAN_HAS_L4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_code == 3'b000 && !bypass_seen |-> res_l4_ok); // R3

    AST_IP_OK_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_ip_ok |-> (res_code == 3'b000 || res_code[2:1] == 2'b11 ||
                                    res_code == 3'b101)); // R9

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && bypass_seen |-> res_code == 3'b000 && !res_ip_ok && !res_l4_ok); // R11

endmodule

bind txcs_classify txcs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_nocrc  (in_nocrc),
    .res_valid (res_valid),
    .res_code  (res_code),
    .res_ip_ok (res_ip_ok),
    .res_l4_ok (res_l4_ok)
);

// File: tb/sim_txcs_classify.sv
module sim_txcs_classify;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_nocrc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       res_valid;
    logic [2:0] res_code;
    logic       res_ip_ok, res_l4_ok;

    always #2 clk = ~clk;

    txcs_classify u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_nocrc(in_nocrc), .in_data(in_data),
        .res_valid(res_valid), .res_code(res_code),
        .res_ip_ok(res_ip_ok), .res_l4_ok(res_l4_ok)
    );

    int         n_run = 0, n_fail = 0;
    bit         finished = 1'b0;
    logic [7:0] fr[$];
    logic [4:0] exp_q[$];
    string      tag_q[$];
    logic [4:0] last_exp = 5'b0;

    task automatic check(input bit ok, input string req, input logic [4:0] act,
                         input logic [4:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got code=%b ip=%b l4=%b, expected code=%b ip=%b l4=%b",
                     req, act[4:2], act[1], act[0], exp[4:2], exp[1], exp[0]);
        end
    endtask

    // monitor: pop the scoreboard on each result pulse
    always @(negedge clk) begin
        if (rst_n && res_valid && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", {res_code, res_ip_ok, res_l4_ok}, 5'b0);
            end else begin
                logic [4:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check({res_code, res_ip_ok, res_l4_ok} == e, t,
                      {res_code, res_ip_ok, res_l4_ok}, e);
            end
        end
    end

    task automatic new_frame();
        fr.delete();
        for (int i = 0; i < 12; i++) fr.push_back(8'(i + 1));
    endtask

    task automatic put16(input logic [15:0] v);
        fr.push_back(v[15:8]);
        fr.push_back(v[7:0]);
    endtask

    task automatic put_bytes(input int n);
        for (int i = 0; i < n; i++) fr.push_back(8'(8'h30 + i));
    endtask

    task automatic put_ip4(input logic [7:0] vi, input logic [7:0] b6,
                           input logic [7:0] b7, input logic [7:0] proto);
        int n;
        n = int'(vi[3:0]) * 4;
        if (n < 20) n = 20;
        for (int k = 0; k < n; k++)
            fr.push_back(k == 0 ? vi : k == 6 ? b6 : k == 7 ? b7 :
                         k == 8 ? 8'd64 : k == 9 ? proto : 8'h00);
    endtask

    task automatic put_ip6(input logic [7:0] first, input logic [7:0] nh);
        for (int k = 0; k < 40; k++)
            fr.push_back(k == 0 ? first : k == 6 ? nh : k == 7 ? 8'd64 : 8'h00);
    endtask

    task automatic trim(input int n);
        for (int i = 0; i < n; i++) void'(fr.pop_back());
    endtask

    task automatic expect_res(input logic [2:0] code, input logic ip, input logic l4,
                              input string req);
        exp_q.push_back({code, ip, l4});
        tag_q.push_back(req);
    endtask

    // driver: stream the built frame; idle gaps carry junk markers that must be ignored
    task automatic send(input bit nocrc, input bit gaps, input bit with_eop);
        for (int i = 0; i < fr.size(); i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(posedge clk); #1;
                in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'hFF;
            end
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = with_eop && (i == fr.size() - 1);
            in_nocrc = nocrc && (i == 0);
            in_data  = fr[i];
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_nocrc = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            check(1'b0, "watchdog expired", 5'b0, 5'b0);
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        check(!res_valid && {res_code, res_ip_ok, res_l4_ok} == 5'b0, "R1 during reset",
              {res_code, res_ip_ok, res_l4_ok}, 5'b0);
        rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        check(!res_valid && {res_code, res_ip_ok, res_l4_ok} == 5'b0, "R1 after reset",
              {res_code, res_ip_ok, res_l4_ok}, 5'b0);

        // R3 plain IPv4 TCP, exactly 18 L4 bytes
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h40, 8'h00, 8'd6); put_bytes(18);
        expect_res(3'b000, 1, 1, "R3 ipv4 tcp"); send(0, 0, 1);
        // R3 and R2: IPv4 UDP with idle gaps carrying junk markers
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h00, 8'd17); put_bytes(8);
        expect_res(3'b000, 1, 1, "R2 R3 ipv4 udp gaps"); send(0, 1, 1);
        idle(6);
        @(negedge clk);
        check(!res_valid && {res_code, res_ip_ok, res_l4_ok} == last_exp, "R2 result held",
              {res_code, res_ip_ok, res_l4_ok}, last_exp);
        // R3 IPv6 UDP; IPv4 with options
        new_frame(); put16(16'h86DD); put_ip6(8'h60, 8'd17); put_bytes(8);
        expect_res(3'b000, 0, 1, "R3 ipv6 udp"); send(0, 0, 1);
        new_frame(); put16(16'h0800); put_ip4(8'h46, 8'h00, 8'h00, 8'd6); put_bytes(20);
        expect_res(3'b000, 1, 1, "R3 ipv4 options"); send(0, 0, 1);
        // R4 tag handling
        new_frame(); put16(16'h8100); put16(16'h0005); put16(16'h0800);
        put_ip4(8'h45, 8'h00, 8'h00, 8'd6); put_bytes(20);
        expect_res(3'b000, 1, 1, "R4 tagged ipv4 tcp"); send(0, 0, 1);
        new_frame(); put16(16'h8100); put16(16'h0005);
        expect_res(3'b001, 0, 0, "R4 ends before inner type"); send(0, 0, 1);
        new_frame(); put16(16'h8100); put16(16'h0005); put16(16'h8100); put_bytes(10);
        expect_res(3'b001, 0, 0, "R4 double tag"); send(0, 0, 1);
        // R5 SNAP
        new_frame(); put16(16'h0040); put16(16'hAAAA); put16(16'h0300); put16(16'h0000);
        put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h00, 8'd17); put_bytes(8);
        expect_res(3'b000, 1, 1, "R5 snap ipv4 udp"); send(0, 0, 1);
        new_frame(); put16(16'h0040); put16(16'hAAAA); put16(16'h0300);
        expect_res(3'b010, 0, 0, "R5 snap truncated"); send(0, 0, 1);
        new_frame(); put16(16'h0040); put16(16'hAAAB); put16(16'h0300); put_bytes(20);
        expect_res(3'b100, 0, 0, "R5 bad llc"); send(0, 0, 1);
        // R6 unrecognised or too short
        new_frame(); put16(16'h88B5); put_bytes(30);
        expect_res(3'b100, 0, 0, "R6 unknown type"); send(0, 0, 1);
        new_frame(); trim(2);
        expect_res(3'b100, 0, 0, "R6 short frame"); send(0, 0, 1);
        // R7 not IP / bad IP header
        new_frame(); put16(16'h8100); put16(16'h0005); put16(16'h0806); put_bytes(28);
        expect_res(3'b011, 0, 0, "R7 tagged non-ip"); send(0, 0, 1);
        new_frame(); put16(16'h0800); put_ip4(8'h55, 8'h00, 8'h00, 8'd6); put_bytes(20);
        expect_res(3'b011, 0, 0, "R7 bad version"); send(0, 0, 1);
        new_frame(); put16(16'h0800); put_ip4(8'h44, 8'h00, 8'h00, 8'd6); put_bytes(20);
        expect_res(3'b011, 0, 0, "R7 ihl below 5"); send(0, 0, 1);
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h00, 8'd6); trim(10);
        expect_res(3'b011, 0, 0, "R7 ip header truncated"); send(0, 0, 1);
        // R8 fragments
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h20, 8'h00, 8'd6); put_bytes(20);
        expect_res(3'b101, 1, 0, "R8 mf set"); send(0, 0, 1);
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h01, 8'd17); put_bytes(8);
        expect_res(3'b101, 1, 0, "R8 nonzero offset"); send(0, 0, 1);
        new_frame(); put16(16'h86DD); put_ip6(8'h60, 8'd44); put_bytes(8);
        expect_res(3'b101, 0, 0, "R8 ipv6 fragment header"); send(0, 0, 1);
        // R9 other protocols
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h00, 8'd1); put_bytes(8);
        expect_res(3'b110, 1, 0, "R9 ipv4 icmp"); send(0, 0, 1);
        new_frame(); put16(16'h86DD); put_ip6(8'h60, 8'd58); put_bytes(8);
        expect_res(3'b110, 0, 0, "R9 ipv6 icmp"); send(0, 0, 1);
        // R10 premature end
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h00, 8'd6); put_bytes(17);
        expect_res(3'b111, 1, 0, "R10 tcp one byte short"); send(0, 0, 1);
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h00, 8'd17); put_bytes(7);
        expect_res(3'b111, 1, 0, "R10 udp one byte short"); send(0, 0, 1);
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h00, 8'd6);
        expect_res(3'b111, 1, 0, "R10 ends at header end"); send(0, 0, 1);
        new_frame(); put16(16'h86DD); put_ip6(8'h60, 8'd6); put_bytes(17);
        expect_res(3'b111, 0, 0, "R10 ipv6 tcp short"); send(0, 0, 1);
        // R11 bypass
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h00, 8'd6); put_bytes(20);
        expect_res(3'b000, 0, 0, "R11 bypass on valid tcp"); send(1, 0, 1);
        new_frame(); put16(16'h1234); put_bytes(10);
        expect_res(3'b000, 0, 0, "R11 bypass on unknown"); send(1, 0, 1);
        // R12 restart mid-frame: unfinished tagged frame, then a full frame
        new_frame(); put16(16'h8100); put16(16'h0005); put_bytes(4);
        send(0, 0, 0);
        new_frame(); put16(16'h0800); put_ip4(8'h45, 8'h00, 8'h00, 8'd17); put_bytes(8);
        expect_res(3'b000, 1, 1, "R12 restart"); send(0, 0, 1);

        idle(8);
        check(exp_q.size() == 0, "R2 R12 result count", 5'(exp_q.size()), 5'b0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule